// File: doc/BRIEF.md
# Constant-Twiddle Radix-2 Butterfly

This block computes one radix-2 decimation-in-time butterfly for a complex twiddle factor that is fixed when the block is built. It takes a complex pair (A, B) in signed Q1.15 form and returns X = A + W·B and Y = A − W·B. It accepts one new pair every clock cycle and has a fixed latency of five cycles. An FFT stage that applies the same twiddle to a stream of pairs can use one instance of it.

The block has no general multiplier. The real and imaginary parts of B are each cut into four 4-bit digits. The lowest three digits are unsigned and the top digit is signed. Each of the four real cross products goes to its own constant-coefficient unit. In that unit, every digit selects an entry from a small table that is computed at elaboration. The weighted table outputs are then summed in two register stages. The complex product is then combined and rescaled, and the butterfly sum and difference follow. All wide additions use Kogge-Stone parallel-prefix adders.

Top module: `cbfly_r2`

## Requirements
- R1: While reset is asserted, and until a valid input has passed through the pipeline, `out_valid` is 0 and all four outputs are 0.
- R2: A pair presented with `in_valid` high on the clock edge of cycle n produces `out_valid` high in cycle n+5 and at no other time.
- R3: The real output X is computed as follows. The real part of W·B is wr = floor((Br·Wr − Bi·Wi) / 2^15). The imaginary part is wi = floor((Br·Wi + Bi·Wr) / 2^15). Then `xr` = Ar + wr and `xi` = Ai + wi. All values are two's complement integers, with the Q1.15 inputs read as integers scaled by 2^15.
- R4: `yr` = Ar − wr and `yi` = Ai − wi, with wr and wi as defined in R3.
- R5: For every valid output, `xr + yr` equals 2·Ar and `xi + yi` equals 2·Ai, taken modulo 2^17.
- R6: When no result is delivered in a cycle, all four outputs keep their previous values.
- R7: Pairs presented on consecutive cycles produce results on consecutive cycles, in order, with no bubbles.
- R8: The twiddle is set by the signed parameters `WR` and `WI` (Q1.15). With WR = 0 and WI = −32768 (that is, −j), X = (Ar + Bi) + j(Ai − Br) exactly, modulo 2^17.
- R9: Outputs are 17-bit two's complement values. Results outside [−65536, 65535] wrap modulo 2^17, with no saturation.
- R10: Each constant unit returns the exact 32-bit product of its 16-bit input and its coefficient. This holds for inputs whose only nonzero bits lie in any single 4-bit digit, including a negative top digit (bit 15 is the sign).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| ar | input | 16 | Real part of A, Q1.15 |
| ai | input | 16 | Imaginary part of A, Q1.15 |
| br | input | 16 | Real part of B, Q1.15 |
| bi | input | 16 | Imaginary part of B, Q1.15 |
| out_valid | output | 1 | Result is valid this cycle |
| xr | output | 17 | Real part of X = A + W·B |
| xi | output | 17 | Imaginary part of X |
| yr | output | 17 | Real part of Y = A − W·B |
| yi | output | 17 | Imaginary part of Y |

## Verification
Because the path has no stalls, a new pair can be accepted in the same cycle as an older result leaves. Stretches of `in_valid` held high are mixed with sparse, gapped stretches to provoke this. Each result is matched in order against a record of its own inputs, and the arrival cycle is checked against the acceptance cycle plus five. In cycles with no result, the outputs are compared with the last delivered values, so that a result released early or late shows up as a change where none is allowed.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int DW    = 16;          // sample width, Q1.15
  localparam int DIG   = 4;           // digit width
  localparam int NDIG  = DW / DIG;    // digits per sample
  localparam int NENT  = 1 << DIG;    // table entries per digit
  localparam int TW    = DW + DIG + 1;// table entry width
  localparam int PW    = 2 * DW;      // full product width
  localparam int OW    = DW + 1;      // output width
  localparam int CW    = OW + 1;      // scaled product width
  localparam int FRAC  = DW - 1;      // fractional bits
  localparam int MLAT  = 3;           // constant-multiplier latency
  localparam int LAT   = MLAT + 2;    // butterfly latency

  // Signed value held by digit code d at slice position k times coefficient c.
  function automatic logic signed [63:0] slice_prod(input int k, input int d, input int c);
    logic signed [63:0] dv;
    if (k == NDIG - 1 && d >= NENT / 2) dv = 64'(d - NENT);
    else                                dv = 64'(d);
    return dv * 64'(c);
  endfunction
endpackage

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] g [0:LV];
  logic [W-1:0] p [0:LV];
  logic [W-1:0] hsum;

  assign hsum = a ^ b;
  assign g[0] = (a & b) | (hsum & {{(W-1){1'b0}}, cin});
  assign p[0] = hsum;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_comb
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-D]);
        assign p[l+1][i] = p[l][i] & p[l][i-D];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  logic [W-1:0] carry;
  if (W > 1) begin : g_cw
    assign carry = {g[LV][W-2:0], cin};
  end else begin : g_c1
    assign carry = cin;
  end
  assign sum = hsum ^ carry;

  logic unused_ok;
  assign unused_ok = ^{g[LV][W-1], p[LV]};
endmodule

// File: rtl/dsl_cmult.sv
module dsl_cmult
  import bfly_pkg::*;
#(
  parameter int C = 23170
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x,
  output logic signed [PW-1:0] prod
);
  // Tables built at elaboration: one per digit position.
  logic signed [TW-1:0] tbl [NDIG][NENT];
  for (genvar k = 0; k < NDIG; k++) begin : g_tab
    for (genvar d = 0; d < NENT; d++) begin : g_ent
      assign tbl[k][d] = TW'(slice_prod(k, d, C));
    end
  end

  // Stage 1: digit lookups.
  logic signed [TW-1:0] pp_q [NDIG];
  for (genvar k = 0; k < NDIG; k++) begin : g_pp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pp_q[k] <= '0;
      else        pp_q[k] <= tbl[k][x[DIG*k +: DIG]];
    end
  end

  // Stage 2: pair sums. Stage 3: final weighted sum.
  logic signed [PW-1:0] lo_q, hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      prod <= '0;
    end else begin
      lo_q <= PW'(pp_q[0]) + (PW'(pp_q[1]) <<< DIG);
      hi_q <= PW'(pp_q[2]) + (PW'(pp_q[3]) <<< DIG);
      prod <= lo_q + (hi_q <<< (2 * DIG));
    end
  end

  // Warm-up counter so the check never reaches behind reset.
  logic [1:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wcnt <= '0;
    else if (wcnt != 2'(MLAT)) wcnt <= wcnt + 2'd1;
  end

  localparam logic signed [PW-1:0] CX = PW'(C);
  logic signed [PW-1:0] x_ext;
  assign x_ext = PW'(x);

  p_exact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt == 2'(MLAT)) |-> (prod == $past(x_ext, MLAT) * CX));
endmodule

// File: rtl/cbfly_r2.sv
module cbfly_r2
  import bfly_pkg::*;
#(
  parameter int WR = 23170,
  parameter int WI = -23170
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [15:0]   ar,
  input  logic signed [15:0]   ai,
  input  logic signed [15:0]   br,
  input  logic signed [15:0]   bi,
  output logic                 out_valid,
  output logic signed [16:0]   xr,
  output logic signed [16:0]   xi,
  output logic signed [16:0]   yr,
  output logic signed [16:0]   yi
);
  localparam int SW = PW + 1;

  // Four constant cross-product units.
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  dsl_cmult #(.C(WR)) u_m_rr (.clk(clk), .rst_n(rst_n), .x(br), .prod(p_rr));
  dsl_cmult #(.C(WI)) u_m_ii (.clk(clk), .rst_n(rst_n), .x(bi), .prod(p_ii));
  dsl_cmult #(.C(WI)) u_m_ri (.clk(clk), .rst_n(rst_n), .x(br), .prod(p_ri));
  dsl_cmult #(.C(WR)) u_m_ir (.clk(clk), .rst_n(rst_n), .x(bi), .prod(p_ir));

  // Complex combine: re = rr - ii, im = ri + ir, then floor-shift.
  logic [SW-1:0] re_full, im_full;
  ks_adder #(.W(SW)) u_add_re (.a(SW'(p_rr)), .b(~SW'(p_ii)), .cin(1'b1), .sum(re_full));
  ks_adder #(.W(SW)) u_add_im (.a(SW'(p_ri)), .b(SW'(p_ir)),  .cin(1'b0), .sum(im_full));

  logic signed [CW-1:0] wbr_q, wbi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbr_q <= '0;
      wbi_q <= '0;
    end else begin
      wbr_q <= CW'(signed'(re_full) >>> FRAC);
      wbi_q <= CW'(signed'(im_full) >>> FRAC);
    end
  end

  // A alignment chain, valid chain.
  logic signed [DW-1:0] are_q [MLAT+1];
  logic signed [DW-1:0] aim_q [MLAT+1];
  for (genvar i = 0; i <= MLAT; i++) begin : g_adly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        are_q[i] <= '0;
        aim_q[i] <= '0;
      end else if (i == 0) begin
        are_q[i] <= ar;
        aim_q[i] <= ai;
      end else begin
        are_q[i] <= are_q[(i == 0) ? 0 : i-1];
        aim_q[i] <= aim_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  logic [LAT-1:0] vld_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], in_valid};
  end
  assign out_valid = vld_q[LAT-1];

  // Butterfly sum and difference.
  logic [CW-1:0] a_re_x, a_im_x, sx_r, sx_i, sy_r, sy_i;
  assign a_re_x = CW'(are_q[MLAT]);
  assign a_im_x = CW'(aim_q[MLAT]);
  ks_adder #(.W(CW)) u_xr (.a(a_re_x), .b(wbr_q),  .cin(1'b0), .sum(sx_r));
  ks_adder #(.W(CW)) u_xi (.a(a_im_x), .b(wbi_q),  .cin(1'b0), .sum(sx_i));
  ks_adder #(.W(CW)) u_yr (.a(a_re_x), .b(~wbr_q), .cin(1'b1), .sum(sy_r));
  ks_adder #(.W(CW)) u_yi (.a(a_im_x), .b(~wbi_q), .cin(1'b1), .sum(sy_i));

  logic load_out;
  assign load_out = vld_q[LAT-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0;
      xi <= '0;
      yr <= '0;
      yi <= '0;
    end else if (load_out) begin
      xr <= OW'(sx_r);
      xi <= OW'(sx_i);
      yr <= OW'(sy_r);
      yi <= OW'(sy_i);
    end
  end

  // Warm-up counter for the checks below.
  logic [3:0] warm;
  logic       warm_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm <= '0;
    else if (warm != 4'(LAT))   warm <= warm + 4'd1;
  end
  assign warm_done = (warm == 4'(LAT));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done |-> (out_valid == $past(in_valid, LAT)));

  p_sum_twice_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && out_valid) |->
      ((OW'(xr + yr) == {$past(are_q[MLAT]), 1'b0}) &&
       (OW'(xi + yi) == {$past(aim_q[MLAT]), 1'b0})));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && !$past(load_out)) |->
      ($stable(xr) && $stable(xi) && $stable(yr) && $stable(yi)));

  p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_done) |-> (xr == '0 && yr == '0 && !out_valid));
endmodule

// File: tb/cbfly_r2_tb_top.sv
`timescale 1ns/1ps
module cbfly_r2_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] ar = '0, ai = '0, br = '0, bi = '0;

  always #10 clk = ~clk;  // 50 MHz

  logic ov_d, ov_1, ov_j;
  logic signed [16:0] xr_d, xi_d, yr_d, yi_d;
  logic signed [16:0] xr_1, xi_1, yr_1, yi_1;
  logic signed [16:0] xr_j, xi_j, yr_j, yi_j;

  cbfly_r2 dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ar(ar), .ai(ai), .br(br), .bi(bi),
                  .out_valid(ov_d), .xr(xr_d), .xi(xi_d), .yr(yr_d), .yi(yi_d));
  cbfly_r2 #(.WR(32767), .WI(0)) dut_one (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ar(ar), .ai(ai),
                  .br(br), .bi(bi), .out_valid(ov_1), .xr(xr_1), .xi(xi_1), .yr(yr_1), .yi(yi_1));
  cbfly_r2 #(.WR(0), .WI(-32768)) dut_mj (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ar(ar), .ai(ai),
                  .br(br), .bi(bi), .out_valid(ov_j), .xr(xr_j), .xi(xi_j), .yr(yr_j), .yi(yi_j));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R1";
  always @(posedge clk) cyc <= cyc + 1;

  // Record of accepted inputs.
  localparam int QN = 4096;
  int q_ar [QN]; int q_ai [QN]; int q_br [QN]; int q_bi [QN]; int q_cy [QN];
  int q_wr = 0;
  int q_rd = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  function automatic longint fl_div(input longint p);
    longint q;
    q = p / 32768;
    if (p < 0 && q * 32768 != p) q = q - 1;
    return q;
  endfunction

  function automatic logic [16:0] w17(input longint v);
    return 17'(v);
  endfunction

  task automatic judge(input string nm, input int wr, input int wi,
                       input logic [16:0] axr, input logic [16:0] axi,
                       input logic [16:0] ayr, input logic [16:0] ayi,
                       input int a_r, input int a_i, input int b_r, input int b_i);
    longint pr, pi;
    pr = fl_div(longint'(b_r) * wr - longint'(b_i) * wi);
    pi = fl_div(longint'(b_r) * wi + longint'(b_i) * wr);
    chk(axr == w17(a_r + pr), {nm, " xr (R3)"}, longint'(axr), longint'(w17(a_r + pr)));
    chk(axi == w17(a_i + pi), {nm, " xi (R3)"}, longint'(axi), longint'(w17(a_i + pi)));
    chk(ayr == w17(a_r - pr), {nm, " yr (R4)"}, longint'(ayr), longint'(w17(a_r - pr)));
    chk(ayi == w17(a_i - pi), {nm, " yi (R4)"}, longint'(ayi), longint'(w17(a_i - pi)));
    chk(17'(axr + ayr) == w17(2 * a_r), {nm, " x+y re (R5)"}, longint'(17'(axr + ayr)), longint'(w17(2 * a_r)));
  endtask

  logic [16:0] last_d [4];

  always @(negedge clk) begin
    if (rst_n && ov_d) begin
      int idx;
      idx = q_rd % QN;
      if (q_rd == q_wr) begin
        chk(1'b0, "output with no pending input (R2)", 1, 0);
      end else begin
        chk(cyc - q_cy[idx] == 5, "latency (R2)", longint'(cyc - q_cy[idx]), 5);
        chk(ov_1 && ov_j, "twiddle variants aligned (R7)", longint'({ov_1, ov_j}), 3);
        judge("diag", 23170, -23170, xr_d, xi_d, yr_d, yi_d, q_ar[idx], q_ai[idx], q_br[idx], q_bi[idx]);
        judge("one", 32767, 0, xr_1, xi_1, yr_1, yi_1, q_ar[idx], q_ai[idx], q_br[idx], q_bi[idx]);
        judge("mj", 0, -32768, xr_j, xi_j, yr_j, yi_j, q_ar[idx], q_ai[idx], q_br[idx], q_bi[idx]);
        if (cur_tag == "R8") begin
          chk(xr_j == w17(q_ar[idx] + q_bi[idx]), "-j xr (R8)", longint'(xr_j), longint'(w17(q_ar[idx] + q_bi[idx])));
          chk(xi_j == w17(q_ai[idx] - q_br[idx]), "-j xi (R8)", longint'(xi_j), longint'(w17(q_ai[idx] - q_br[idx])));
        end
        q_rd++;
      end
      last_d[0] = xr_d; last_d[1] = xi_d; last_d[2] = yr_d; last_d[3] = yi_d;
    end else if (rst_n && cur_tag == "R6") begin
      chk({xr_d, xi_d, yr_d, yi_d} == {last_d[0], last_d[1], last_d[2], last_d[3]},
          "outputs held in idle cycle (R6)", longint'(xr_d), longint'(last_d[0]));
    end
  end

  task automatic put(input int a_r, input int a_i, input int b_r, input int b_i);
    ar = 16'(a_r); ai = 16'(a_i); br = 16'(b_r); bi = 16'(b_i);
    in_valid = 1'b1;
    q_ar[q_wr % QN] = int'(signed'(16'(a_r)));
    q_ai[q_wr % QN] = int'(signed'(16'(a_i)));
    q_br[q_wr % QN] = int'(signed'(16'(b_r)));
    q_bi[q_wr % QN] = int'(signed'(16'(b_i)));
    q_cy[q_wr % QN] = cyc;
    q_wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(8);
    chk(q_rd == q_wr, "all results delivered (R2)", longint'(q_rd), longint'(q_wr));
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic t_reset();
    cur_tag = "R1";
    chk(!ov_d && !ov_1 && !ov_j, "out_valid low in reset (R1)", longint'(ov_d), 0);
    chk(xr_d == 0 && xi_d == 0 && yr_d == 0 && yi_d == 0, "outputs zero in reset (R1)", longint'(xr_d), 0);
    rst_n = 1'b1;
    idle(3);
    chk(!ov_d && xr_d == 0, "idle after reset (R1)", longint'(ov_d), 0);
  endtask

  task automatic t_corners();
    cur_tag = "R3";
    put(0, 0, 32767, 0);      idle(2);
    put(1000, -2000, -32768, -32768); idle(1);
    put(-5, 7, 12345, -23456);
    put(-32768, 32767, 1, -1);
    drain();
  endtask

  task automatic t_minus_j();
    cur_tag = "R8";
    put(100, 200, 300, 400);
    put(-32768, -32768, -32768, 32767);
    put(32767, 0, -1, -32768);
    drain();
  endtask

  task automatic t_stream();
    cur_tag = "R7";
    for (int i = 0; i < 300; i++) begin
      lfsr = nxt(lfsr);
      ar = 16'(lfsr[15:0]);
      lfsr = nxt(lfsr);
      put(int'(signed'(lfsr[31:16])), int'(signed'(lfsr[15:0])),
          int'(signed'(16'(lfsr[23:8]))), int'(signed'(16'(lfsr[27:12]))));
    end
    drain();
  endtask

  task automatic t_gaps();
    cur_tag = "R6";
    for (int i = 0; i < 40; i++) begin
      lfsr = nxt(lfsr);
      put(int'(signed'(lfsr[15:0])), int'(signed'(lfsr[31:16])),
          int'(signed'(16'(lfsr[20:5]))), int'(signed'(16'(lfsr[30:15]))));
      idle(int'(lfsr[2:0]) + 1);
    end
    drain();
  endtask

  task automatic t_wrap();
    cur_tag = "R9";
    put(32767, 32767, 32767, 32767);
    put(-32768, -32768, -32768, -32768);
    put(32767, -32768, -32768, 32767);
    drain();
  endtask

  task automatic t_digits();
    cur_tag = "R10";
    put(0, 0, 16'h000F, 16'h00F0);
    put(0, 0, 16'h0F00, 16'hF000);
    put(0, 0, 16'h8000, 16'h7FFF);
    put(0, 0, 16'h0009, 16'h9000);
    drain();
  endtask

  initial begin
    idle(4);
    t_reset();
    t_corners();
    t_minus_j();
    t_stream();
    t_gaps();
    t_wrap();
    t_digits();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule